// File: doc/BRIEF.md
# Video Output Range Limiter

This block is the last conditioning stage on an interleaved 4:2:2 component byte stream before the stream leaves a video decoder. Each incoming byte is tagged by a free-running 2-bit phase counter as a Cb, Y, Cr or Y sample. The counter restarts on a start-of-active-video strobe. Tagged bytes then go through two operations in a fixed order. First, on vertical-blanking lines, colour-difference samples can be forced to the neutral level, so ancillary data carried on those lines is not turned into false colour. Second, every luma and chroma byte is clamped into one of two selectable code ranges.

Bytes that the upstream timing logic flags as part of a timing-reference header bypass both operations unchanged. Only such bytes may carry the reserved codes 0x00 and 0xFF. The range select and the blank enable are captured only at the start-of-active-video strobe, so each line is processed with a single consistent set of settings. The result is registered and appears one clock after the input byte.

Top module: `vout_limiter`

## Requirements
- R1: `outValid` equals `inValid` delayed by exactly one clock. `outData` takes the processed byte one clock after a byte with `inValid` high and holds its value through cycles with `inValid` low.
- R2: While `rstN` is low, `outValid` is 0 and `outData` is 0x00. The captured blank enable resets to 1, the captured range select resets to 1, and the phase counter resets to 0.
- R3: A cycle with `sav` high sets the phase counter to 0. Each valid byte with `inHdr` low advances the counter by one, modulo 4. Phases 0, 1, 2 and 3 label Cb, Y, Cr and Y. An even phase (bit 0 = 0) is chroma and an odd phase is luma.
- R4: When the captured blank enable is 1 and `vbiLine` is high, each non-header chroma byte leaves as 0x80. When the captured blank enable is 0, chroma on such lines passes through the clamp only. Luma is never blanked. Blanking is applied before clamping.
- R5: With captured range select 0, non-header luma is clamped to 16..235 (0x10..0xEB) and non-header chroma to 16..240 (0x10..0xF0).
- R6: With captured range select 1, every non-header byte is clamped to 1..254 (0x01..0xFE).
- R7: A valid byte with `inHdr` high leaves unchanged and does not advance the phase counter.
- R8: `rangeSel` and `blankEn` are captured only in a cycle with `sav` high, and take effect from the next cycle. Changing them at any other time has no effect on output until the next `sav`.
- R9: A valid output byte whose input was not a header byte is never 0x00 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Incoming sample byte |
| inValid | input | 1 | Marks `inData` as a sample this cycle |
| inHdr | input | 1 | Byte belongs to a timing-reference header |
| sav | input | 1 | Start-of-active-video strobe; restarts phase and captures settings |
| vbiLine | input | 1 | Current line is a vertical-blanking line |
| blankEn | input | 1 | Requested chroma blanking on blanking lines |
| rangeSel | input | 1 | Requested range: 0 narrow, 1 wide |
| outData | output | 8 | Conditioned sample byte, registered |
| outValid | output | 1 | Marks `outData` as a new sample |

## Verification
Every data result is due exactly one clock after the byte is presented. The bench drives each byte on a falling edge and checks `outData` and `outValid` 1 ns after the following rising edge, which is the one edge that captures it. A setting change or `sav` strobe affects only bytes presented in later cycles, so the bench presents its bytes in the cycles after the strobe. It predicts the result of each byte from its own phase and captured-settings model. Idle cycles are checked at the same point, to confirm that `outValid` is low and `outData` holds.

// File: rtl/vout_limiter_pkg.sv
package vout_limiter_pkg;
  // Per-byte strobes from the control half to the datapath half
  typedef struct packed {
    logic chromaSlot;   // current byte is Cb or Cr
    logic blankNow;     // replace this byte with the neutral level
    logic narrowRange;  // use the narrow limits for this line
  } limStrobe_t;
endpackage

// File: rtl/vout_limiter_ctrl.sv
module vout_limiter_ctrl
  import vout_limiter_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inHdr,
  input  logic       sav,
  input  logic       vbiLine,
  input  logic       blankEn,
  input  logic       rangeSel,
  output limStrobe_t strobe
);
  localparam int PHASE_W = $clog2(SLOTS);

  logic [PHASE_W-1:0] phase;
  logic               lineBlank;
  logic               lineWide;

  // Phase counter: restart on sav, step on each non-header sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (sav) begin
      phase <= '0;
    end else if (inValid && !inHdr) begin
      phase <= phase + 1'b1;
    end
  end

  // Per-line settings, captured at the start-of-active-video strobe only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBlank <= 1'b1;
      lineWide  <= 1'b1;
    end else if (sav) begin
      lineBlank <= blankEn;
      lineWide  <= rangeSel;
    end
  end

  always_comb begin
    strobe.chromaSlot  = ~phase[0];
    strobe.blankNow    = lineBlank & vbiLine & ~phase[0];
    strobe.narrowRange = ~lineWide;
  end
endmodule

// File: rtl/vout_limiter_dp.sv
module vout_limiter_dp
  import vout_limiter_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLANK_VAL   = 128,
  parameter int NARROW_LO   = 16,
  parameter int NARROW_Y_HI = 235,
  parameter int NARROW_C_HI = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inHdr,
  input  limStrobe_t        strobe,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  localparam logic [DATA_W-1:0] WIDE_LO  = DATA_W'(1);
  localparam logic [DATA_W-1:0] WIDE_HI  = DATA_W'((1 << DATA_W) - 2);
  localparam logic [DATA_W-1:0] NAR_LO   = DATA_W'(NARROW_LO);
  localparam logic [DATA_W-1:0] NAR_Y_HI = DATA_W'(NARROW_Y_HI);
  localparam logic [DATA_W-1:0] NAR_C_HI = DATA_W'(NARROW_C_HI);
  localparam logic [DATA_W-1:0] NEUTRAL  = DATA_W'(BLANK_VAL);

  logic [DATA_W-1:0] blanked;
  logic [DATA_W-1:0] loLim;
  logic [DATA_W-1:0] hiLim;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] nextData;

  // Blanking first, then clamping
  always_comb begin
    blanked = strobe.blankNow ? NEUTRAL : inData;
    if (strobe.narrowRange) begin
      loLim = NAR_LO;
      hiLim = strobe.chromaSlot ? NAR_C_HI : NAR_Y_HI;
    end else begin
      loLim = WIDE_LO;
      hiLim = WIDE_HI;
    end
    if (blanked < loLim) begin
      clamped = loLim;
    end else if (blanked > hiLim) begin
      clamped = hiLim;
    end else begin
      clamped = blanked;
    end
    nextData = inHdr ? inData : clamped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outData <= nextData;
      end
    end
  end
endmodule

// File: rtl/vout_limiter.sv
module vout_limiter
  import vout_limiter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inHdr,
  input  logic              sav,
  input  logic              vbiLine,
  input  logic              blankEn,
  input  logic              rangeSel,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  limStrobe_t strobe;

  vout_limiter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inHdr    (inHdr),
    .sav      (sav),
    .vbiLine  (vbiLine),
    .blankEn  (blankEn),
    .rangeSel (rangeSel),
    .strobe   (strobe)
  );

  vout_limiter_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .inHdr    (inHdr),
    .strobe   (strobe),
    .outData  (outData),
    .outValid (outValid)
  );
endmodule

// File: rtl/vout_limiter_chk.sv
module vout_limiter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] inData,
  input logic              inValid,
  input logic              inHdr,
  input logic [DATA_W-1:0] outData,
  input logic              outValid
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outData)));  // R1
  AST_HDR_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inHdr) |=> (outData == $past(inData)));  // R7
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inHdr)) |-> (outData != '0 && outData != '1));  // R9
endmodule

bind vout_limiter vout_limiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inData   (inData),
  .inValid  (inValid),
  .inHdr    (inHdr),
  .outData  (outData),
  .outValid (outValid)
);

// File: tb/vout_limiter_bench.sv
`timescale 1ns/1ps
module vout_limiter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inHdr = 1'b0;
  logic       sav = 1'b0;
  logic       vbiLine = 1'b0;
  logic       blankEn = 1'b1;
  logic       rangeSel = 1'b1;
  logic [7:0] outData;
  logic       outValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model state, from the requirements
  logic [1:0] bPhase = 2'd0;
  logic       bBlank = 1'b1;
  logic       bWide  = 1'b1;
  logic [7:0] lastOut = 8'h00;

  always #2 clk = ~clk;

  vout_limiter u_vout_limiter (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inHdr(inHdr),
    .sav(sav), .vbiLine(vbiLine), .blankEn(blankEn), .rangeSel(rangeSel),
    .outData(outData), .outValid(outValid)
  );

  function automatic logic [7:0] model(input logic [7:0] d, input logic hdr,
                                       input logic [1:0] ph, input logic blk,
                                       input logic wide, input logic vbi);
    logic       chroma;
    logic [7:0] v, lo, hi;
    if (hdr) return d;
    chroma = ~ph[0];
    v  = (blk && vbi && chroma) ? 8'h80 : d;
    lo = wide ? 8'h01 : 8'h10;
    hi = wide ? 8'hFE : (chroma ? 8'hF0 : 8'hEB);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one byte, check it one clock later
  task automatic sendByte(input logic [7:0] d, input logic hdr, input string req);
    logic [7:0] exp;
    @(negedge clk);
    inData = d; inHdr = hdr; inValid = 1'b1; sav = 1'b0;
    exp = model(d, hdr, bPhase, bBlank, bWide, vbiLine);
    if (!hdr) bPhase = bPhase + 2'd1;
    @(posedge clk); #1;
    check(req, outData, exp);
    check({req, " valid R1"}, {7'd0, outValid}, 8'd1);
    lastOut = exp;
  endtask

  // Start-of-active-video on a header status byte
  task automatic doSav(input logic wide, input logic blk);
    @(negedge clk);
    rangeSel = wide; blankEn = blk;
    inData = 8'h80; inHdr = 1'b1; inValid = 1'b1; sav = 1'b1;
    @(posedge clk); #1;
    check("R7 sav header byte", outData, 8'h80);
    lastOut = 8'h80;
    bPhase = 2'd0; bBlank = blk; bWide = wide;
    @(negedge clk); sav = 1'b0; inValid = 1'b0; inHdr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    #1;
    check("R2 reset outValid", {7'd0, outValid}, 8'd0);
    check("R2 reset outData", outData, 8'h00);
  endtask

  task automatic testResetSettings();
    // No sav yet: wide range and blanking on from reset, phase 0 = Cb
    vbiLine = 1'b1;
    sendByte(8'h22, 1'b0, "R2 R4 reset blank Cb");
    sendByte(8'hFF, 1'b0, "R2 R6 reset wide Y");
    vbiLine = 1'b0;
  endtask

  task automatic testWide();
    doSav(1'b1, 1'b1);
    sendByte(8'h00, 1'b0, "R6 R9 wide Cb low");
    sendByte(8'hFF, 1'b0, "R6 R9 wide Y high");
    sendByte(8'h80, 1'b0, "R6 wide Cr mid");
    sendByte(8'h10, 1'b0, "R6 wide Y in range");
  endtask

  task automatic testNarrow();
    doSav(1'b0, 1'b1);
    sendByte(8'h05, 1'b0, "R5 narrow Cb low");
    sendByte(8'hF0, 1'b0, "R5 narrow Y high");
    sendByte(8'hF5, 1'b0, "R5 narrow Cr high");
    sendByte(8'h00, 1'b0, "R5 narrow Y zero");
    sendByte(8'hEE, 1'b0, "R5 R3 narrow Cb 238 kept");
    sendByte(8'hEE, 1'b0, "R5 R3 narrow Y 238 clamped");
  endtask

  task automatic testBlank();
    doSav(1'b1, 1'b1);
    vbiLine = 1'b1;
    sendByte(8'h33, 1'b0, "R4 blank Cb");
    sendByte(8'h33, 1'b0, "R4 luma not blanked");
    sendByte(8'hFF, 1'b0, "R4 blank Cr");
    sendByte(8'h00, 1'b0, "R4 R9 luma clamped");
    doSav(1'b1, 1'b0);
    sendByte(8'h33, 1'b0, "R4 blank off Cb passes");
    sendByte(8'h44, 1'b0, "R4 blank off Y");
    sendByte(8'hFF, 1'b0, "R4 blank off Cr clamped");
    vbiLine = 1'b0;
  endtask

  task automatic testHeader();
    doSav(1'b0, 1'b1);
    sendByte(8'h50, 1'b0, "R3 Cb");
    sendByte(8'hFF, 1'b1, "R7 header FF");
    sendByte(8'h00, 1'b1, "R7 header 00");
    sendByte(8'hF2, 1'b0, "R7 R3 phase kept, Y clamp 235");
    sendByte(8'hF2, 1'b0, "R3 Cr clamp 240");
  endtask

  task automatic testLatch();
    doSav(1'b1, 1'b1);
    @(negedge clk); rangeSel = 1'b0; blankEn = 1'b0;
    vbiLine = 1'b1;
    sendByte(8'h20, 1'b0, "R8 blank still on");
    sendByte(8'hF5, 1'b0, "R8 wide still on");
    vbiLine = 1'b0;
    doSav(1'b0, 1'b0);
    sendByte(8'h02, 1'b0, "R8 narrow after sav");
  endtask

  task automatic testSavRestart();
    doSav(1'b0, 1'b1);
    sendByte(8'hF5, 1'b0, "R3 Cb");
    doSav(1'b0, 1'b1);
    sendByte(8'hF5, 1'b0, "R3 restart Cb limit 240");
  endtask

  task automatic testIdle();
    @(negedge clk); inValid = 1'b0; inData = 8'h00; inHdr = 1'b0;
    @(posedge clk); #1;
    check("R1 idle valid low", {7'd0, outValid}, 8'd0);
    @(posedge clk); #1;
    check("R1 idle data holds", outData, lastOut);
  endtask

  initial begin
    testReset();
    repeat (3) @(posedge clk);
    #1; testReset();
    @(negedge clk); rstN = 1'b1;
    testResetSettings();
    testIdle();
    testWide();
    testNarrow();
    testIdle();
    testBlank();
    testHeader();
    testLatch();
    testSavRestart();
    testIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule